// File: doc/BRIEF.md
# Quadrature Encoder Position Tracker

This block follows the shaft of a DC motor by watching the two square-wave channels of an incremental optical encoder. Both channels and a home switch are first brought into the system clock domain through a short flip-flop chain. The synchronised A/B pair then drives a four-state machine that tracks the current quarter-cycle of the encoder waveform. Each legal move to a neighbouring state produces a one-clock step pulse, either up or down, and a position register follows those pulses.

A pair that changes both bits at once cannot come from real motion. It is flagged as a jump in a sticky error bit, it leaves the count untouched, and the machine re-locks onto the new levels. Asserting the home switch defines the absolute zero of the position register. The position and step outputs feed a motion controller or a display path elsewhere on the chip.

Top module: `qenc_tracker`

## Requirements
- R1: A level change on enc_a or enc_b appears as a step pulse on the third rising clock edge after it is applied, never earlier.
- R2: States use the codes {enc_a,enc_b}: S0=10, S1=11, S2=01, S3=00. The forward order S0→S1→S2→S3→S0 produces one step_up pulse per transition, and pos rises by one in the same cycle.
- R3: The reverse order S0→S3→S2→S1→S0 produces one step_dn pulse per transition, and pos falls by one in the same cycle.
- R4: While the synchronised pair equals the current state's code, no pulse is produced and pos holds its value.
- R5: Each step pulse lasts one clock per transition, and step_up and step_dn are never high together.
- R6: A pair differing from the current code in both bits changes no count and emits no pulse. It sets jump_err, which stays high until reset, and the state takes the new code so that later steps decode from it.
- R7: pos is 12 bits wide by default and wraps modulo 4096 in both directions (4095+1=0, 0-1=4095).
- R8: While the synchronised home_sw is high, pos is cleared to zero. This clear wins over a step decoded in the same cycle; the step pulse itself is still emitted.
- R9: An asynchronous active-low reset gives state S0, pos=0, both pulses low and jump_err low. The synchronisers reset to the S0 levels, so an encoder resting at A=1,B=0 produces no pulse on reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| home_sw | input | 1 | Home switch, active high, asynchronous |
| pos | output | POS_W (12) | Tracked position |
| step_up | output | 1 | One-clock pulse per forward step |
| step_dn | output | 1 | One-clock pulse per reverse step |
| jump_err | output | 1 | Sticky flag for a double-bit jump |

## Verification
A wrong state code shows up at the first step after it. The pulse comes out in the wrong direction, or comes out as a jump with no pulse, so pos leaves the reference count within three clocks of the input edge. Because the position register integrates every step, a single lost or extra pulse leaves a permanent offset that every later comparison exposes. The bench follows each input change with its expected pulse and value, and it checks the pauses, the jumps and the home clears against its own counted reference.

// File: rtl/qenc_tracker.sv
module qenc_tracker #(
  parameter int POS_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             home_sw,
  output logic [POS_W-1:0] pos,
  output logic             step_up,
  output logic             step_dn,
  output logic             jump_err
);

  localparam int SMSB = SYNC_STAGES - 1;
  localparam logic [1:0] CODE_S0 = 2'b10;
  localparam logic [1:0] CODE_S1 = 2'b11;
  localparam logic [1:0] CODE_S2 = 2'b01;
  localparam logic [1:0] CODE_S3 = 2'b00;

  logic [SMSB:0] a_sync, b_sync, h_sync;
  logic [1:0]    cur, pair;
  logic          home_s, is_up, is_dn, is_jump;

  function automatic logic [1:0] next_fwd(input logic [1:0] c);
    case (c)
      CODE_S0: next_fwd = CODE_S1;
      CODE_S1: next_fwd = CODE_S2;
      CODE_S2: next_fwd = CODE_S3;
      default: next_fwd = CODE_S0;
    endcase
  endfunction

  function automatic logic [1:0] next_rev(input logic [1:0] c);
    case (c)
      CODE_S0: next_rev = CODE_S3;
      CODE_S3: next_rev = CODE_S2;
      CODE_S2: next_rev = CODE_S1;
      default: next_rev = CODE_S0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sync <= '1;
      b_sync <= '0;
      h_sync <= '0;
    end else begin
      a_sync <= {a_sync[SMSB-1:0], enc_a};
      b_sync <= {b_sync[SMSB-1:0], enc_b};
      h_sync <= {h_sync[SMSB-1:0], home_sw};
    end
  end

  assign pair    = {a_sync[SMSB], b_sync[SMSB]};
  assign home_s  = h_sync[SMSB];
  assign is_up   = (pair == next_fwd(cur));
  assign is_dn   = (pair == next_rev(cur));
  assign is_jump = (pair == ~cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= CODE_S0;
      step_up  <= 1'b0;
      step_dn  <= 1'b0;
      jump_err <= 1'b0;
      pos      <= '0;
    end else begin
      cur     <= pair;
      step_up <= is_up;
      step_dn <= is_dn;
      if (is_jump) jump_err <= 1'b1;
      if (home_s)     pos <= '0;
      else if (is_up) pos <= pos + 1'b1;
      else if (is_dn) pos <= pos - 1'b1;
    end
  end

endmodule

module qenc_tracker_chk #(
  parameter int POS_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             home_s,
  input logic [POS_W-1:0] pos,
  input logic             step_up,
  input logic             step_dn,
  input logic             jump_err
);

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn)); // R5

  AST_UP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !$past(home_s)) |-> pos == POS_W'($past(pos) + 1'b1)); // R2

  AST_DN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !$past(home_s)) |-> pos == POS_W'($past(pos) - 1'b1)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_dn && !$past(home_s)) |-> $stable(pos)); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    jump_err |=> jump_err); // R6

  AST_HOME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    home_s |=> pos == '0); // R8

endmodule

bind qenc_tracker qenc_tracker_chk #(.POS_W(POS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .home_s(home_s), .pos(pos),
  .step_up(step_up), .step_dn(step_dn), .jump_err(jump_err)
);

// File: tb/qenc_tracker_tb_top.sv
module qenc_tracker_tb_top;
  localparam int POS_W = 12;
  localparam int MAXC  = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b1, enc_b = 1'b0, home_sw = 1'b0;
  logic [POS_W-1:0] pos;
  logic step_up, step_dn, jump_err;

  int n_chk = 0, n_fail = 0;
  logic [1:0] code = 2'b10;
  logic [POS_W-1:0] pos_ref = '0;
  logic [POS_W+1:0] exp_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  qenc_tracker #(.POS_W(POS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .home_sw(home_sw),
    .pos(pos), .step_up(step_up), .step_dn(step_dn), .jump_err(jump_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] fwd(input logic [1:0] c);
    case (c)
      2'b10: fwd = 2'b11;
      2'b11: fwd = 2'b01;
      2'b01: fwd = 2'b00;
      default: fwd = 2'b10;
    endcase
  endfunction

  function automatic logic [1:0] rev(input logic [1:0] c);
    case (c)
      2'b10: rev = 2'b00;
      2'b00: rev = 2'b01;
      2'b01: rev = 2'b11;
      default: rev = 2'b10;
    endcase
  endfunction

  task automatic drive_step(input bit up, input bit homed);
    code = up ? fwd(code) : rev(code);
    {enc_a, enc_b} = code;
    if (homed) pos_ref = '0;
    else pos_ref = up ? pos_ref + 1'b1 : pos_ref - 1'b1;
    exp_q.push_back({up, !up, pos_ref});
  endtask

  task automatic step(input bit up);
    drive_step(up, home_sw);
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && (step_up || step_dn)) begin
      if (exp_q.size() == 0) begin
        check(0, "R4/R6 unexpected pulse", {step_up, step_dn}, 0);
      end else begin
        logic [POS_W+1:0] e;
        e = exp_q.pop_front();
        check({step_up, step_dn} == e[POS_W+1:POS_W], "R2/R3/R5 pulse kind",
              {step_up, step_dn}, e[POS_W+1:POS_W]);
        check(pos == e[POS_W-1:0], "R2/R3/R7/R8 pos after step", pos, e[POS_W-1:0]);
      end
    end
  end

  initial begin
    repeat (MAXC) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R9 reset state
    check(pos == 0, "R9 pos", pos, 0);
    check(!step_up && !step_dn, "R9 pulses", {step_up, step_dn}, 0);
    check(!jump_err, "R9 jump_err", jump_err, 0);

    // R1 latency
    drive_step(1, 0);
    @(negedge clk);
    check(!step_up, "R1 early edge 1", step_up, 0);
    @(negedge clk);
    check(!step_up, "R1 early edge 2", step_up, 0);
    @(negedge clk);
    check(step_up, "R1 third edge", step_up, 1);
    @(negedge clk);

    // R2 forward run
    for (int i = 0; i < 10; i++) step(1);
    check(pos == pos_ref, "R2 forward count", pos, pos_ref);

    // R4 pause
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(pos == pos_ref, "R4 hold", pos, pos_ref);
    end

    // R3 and R7 reverse through zero
    for (int i = 0; i < 15; i++) step(0);
    check(pos == 12'd4092, "R7 reverse wrap", pos, 4092);
    // R7 forward through 4095
    for (int i = 0; i < 6; i++) step(1);
    check(pos == 12'd2, "R7 forward wrap", pos, 2);

    // R6 illegal jump
    code = ~code;
    {enc_a, enc_b} = code;
    repeat (6) @(negedge clk);
    check(jump_err, "R6 flag", jump_err, 1);
    check(pos == pos_ref, "R6 no count", pos, pos_ref);
    step(1);
    check(pos == pos_ref, "R6 resync", pos, pos_ref);
    step(0);
    check(jump_err, "R6 sticky", jump_err, 1);

    // R8 home
    home_sw = 1'b1;
    pos_ref = '0;
    repeat (4) @(negedge clk);
    check(pos == 0, "R8 clear", pos, 0);
    step(1);
    check(pos == 0, "R8 priority over step", pos, 0);
    home_sw = 1'b1;
    drive_step(1, 1);
    repeat (4) @(negedge clk);
    home_sw = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) step(1);
    check(pos == 12'd3, "R8 count after home", pos, 3);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 missing pulses", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule